// File: doc/BRIEF.md
# Range-Gated Two-Page Sample Buffer

This block captures a decimated complex sample stream into one page of a two-page memory while a timed range gate is open. Strobes open and close the gate. The write position is kept when the gate closes, so several gate windows in one collection period pack one after another into the same page. A flip strobe exchanges the page roles. The page that was just filled becomes readable through a plain address/data port, starting at address 0, and the other page becomes the new write target with its write position back at 0.

A start-compute strobe then raises a level interrupt to the host, and the interrupt stays high until the host acknowledges it. The block enforces the ordering rules. A flip that arrives while the gate is open is refused and reported. A start-compute that comes too soon after the last accepted flip is refused and reported. A write page that fills up drops further samples and sets a sticky overflow flag.

The sample input carries a valid qualifier but no ready. The source cannot be stalled, and any sample that is not stored is discarded. All control strobes are single-cycle pulses.

Top module: `pingpong_gate_buf`

## Requirements
- R1: A sample with `in_valid` high is stored when the gate is open. This includes the cycle in which `gate_open` is pulsed and the cycle in which `gate_close` is pulsed. A sample is discarded when the gate is closed and `gate_open` is low.
- R2: Each stored sample goes to the next write address, starting at 0. The write address is not reset when the gate closes, so later gate windows continue where the previous window stopped.
- R3: A flip accepted while the gate is closed exchanges the pages. Afterwards, readable address k returns the k-th sample stored before the flip, and the next stored sample goes to address 0 of the other page.
- R4: A flip pulsed while the gate is open, or in the same cycle as `gate_open`, does not exchange the pages. It pulses `flip_err` for one cycle, visible after the next clock edge.
- R5: A `stc` pulse given FLIP_GAP or more cycles after the last accepted flip sets `irq` at the next clock edge. With FLIP_GAP=15, the pulse 15 clock edges after the flip edge is the first one accepted. An earlier `stc` leaves `irq` unchanged and pulses `stc_err`.
- R6: Once set, `irq` stays high until an `irq_ack` pulse, which clears it at the next edge. An accepted `stc` in the same cycle as `irq_ack` wins.
- R7: When the write page already holds 2^ADDR_W samples, further samples are dropped and `overflow` is set and held. An accepted flip clears `overflow`.
- R8: `rd_data` presents the readable-page word at the `rd_addr` sampled on the previous clock edge. The word is packed as {real, imaginary}, with the real part in the upper DATA_W bits.
- R9: After reset, `irq`, `overflow`, `flip_err` and `stc_err` are low, the gate is closed, and the write address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | DATA_W | Real part of sample |
| in_im | input | DATA_W | Imaginary part of sample |
| gate_open | input | 1 | Open the range gate (pulse) |
| gate_close | input | 1 | Close the range gate (pulse) |
| flip | input | 1 | Exchange write and read pages (pulse) |
| stc | input | 1 | Start-compute: request host interrupt (pulse) |
| irq_ack | input | 1 | Host clears the interrupt (pulse) |
| rd_addr | input | ADDR_W | Host read address within the readable page |
| rd_data | output | 2*DATA_W | Read word {re, im}, one cycle after address |
| irq | output | 1 | Host interrupt, level-held |
| overflow | output | 1 | Write page full, samples dropped (sticky) |
| flip_err | output | 1 | Flip refused because the gate was open (pulse) |
| stc_err | output | 1 | Start-compute refused because it came too soon after a flip (pulse) |

## Verification
Each result is due a fixed number of cycles after its stimulus. A stored sample is readable one edge after the flip that exposes it. `rd_data` follows `rd_addr` by one edge. `irq`, `flip_err`, `stc_err` and `overflow` change at the edge that samples their cause. The bench drives each stimulus half a cycle before an edge and reads the outputs at the falling edge right after it, so every check lands in the first cycle in which its result is due. The start-compute spacing is probed at both sides of its boundary, one cycle early and exactly on time.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_LIVE = 1'b1
  } gate_e;
endpackage

// File: rtl/pgb_ram.sv
module pgb_ram #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W:0]   waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W:0]   raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int WORDS = 2 << ADDR_W;

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgb_wr_ctrl.sv
module pgb_wr_ctrl
  import pgb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              flip_i,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_page,
  output logic              flip_ok,
  output logic              flip_err,
  output logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL_MARK = (ADDR_W+1)'(DEPTH);

  gate_e           gate_q;
  logic [ADDR_W:0] ptr;
  logic            gate_live;
  logic            store_try;
  logic            full;

  assign gate_live = (gate_q == GATE_LIVE) || open_i;
  assign store_try = valid_i && gate_live;
  assign full      = (ptr == FULL_MARK);
  assign wr_en     = store_try && !full;
  assign wr_addr   = ptr[ADDR_W-1:0];
  assign flip_ok   = flip_i && !gate_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= GATE_SHUT;
      ptr      <= '0;
      wr_page  <= 1'b0;
      overflow <= 1'b0;
      flip_err <= 1'b0;
    end else begin
      if (close_i)     gate_q <= GATE_SHUT;
      else if (open_i) gate_q <= GATE_LIVE;

      if (flip_ok)    ptr <= '0;
      else if (wr_en) ptr <= ptr + 1'b1;

      if (flip_ok)                overflow <= 1'b0;
      else if (store_try && full) overflow <= 1'b1;

      if (flip_ok) wr_page <= ~wr_page;
      flip_err <= flip_i && gate_live;
    end
  end

  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= FULL_MARK);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flip_ok |=> overflow);

  p_ptr_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ok |=> (ptr == '0) && !overflow);

  p_flip_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flip_i && (gate_q == GATE_LIVE) |=> flip_err && $stable(wr_page));

  p_gate_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    close_i && !flip_ok |=> $stable(ptr) || ($past(wr_en) && ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/pgb_stc_ctrl.sv
module pgb_stc_ctrl #(
  parameter int FLIP_GAP = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_ok,
  input  logic stc_i,
  input  logic ack_i,
  output logic irq,
  output logic stc_err
);
  localparam int CW = $clog2(FLIP_GAP + 1);
  localparam logic [CW-1:0] GAP = CW'(FLIP_GAP);

  logic [CW-1:0] since_flip;
  logic          stc_ok;

  assign stc_ok = (since_flip >= GAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_flip <= GAP;
      irq        <= 1'b0;
      stc_err    <= 1'b0;
    end else begin
      if (flip_ok)            since_flip <= CW'(1);
      else if (!stc_ok)       since_flip <= since_flip + 1'b1;

      if (stc_i && stc_ok)    irq <= 1'b1;
      else if (ack_i)         irq <= 1'b0;

      stc_err <= stc_i && !stc_ok;
    end
  end

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_i |=> irq);

  p_early_stc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stc_i && (since_flip < GAP) && !irq |=> !irq && stc_err);

  p_stc_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stc_i && (since_flip >= GAP) |=> irq);
endmodule

// File: rtl/pingpong_gate_buf.sv
module pingpong_gate_buf #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int FLIP_GAP = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_re,
  input  logic [DATA_W-1:0]   in_im,
  input  logic                gate_open,
  input  logic                gate_close,
  input  logic                flip,
  input  logic                stc,
  input  logic                irq_ack,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [2*DATA_W-1:0] rd_data,
  output logic                irq,
  output logic                overflow,
  output logic                flip_err,
  output logic                stc_err
);
  localparam int WORD_W = 2 * DATA_W;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              wr_page;
  logic              flip_ok;

  pgb_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (in_valid),
    .open_i   (gate_open),
    .close_i  (gate_close),
    .flip_i   (flip),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_page  (wr_page),
    .flip_ok  (flip_ok),
    .flip_err (flip_err),
    .overflow (overflow)
  );

  pgb_stc_ctrl #(.FLIP_GAP(FLIP_GAP)) u_stc (
    .clk     (clk),
    .rst_n   (rst_n),
    .flip_ok (flip_ok),
    .stc_i   (stc),
    .ack_i   (irq_ack),
    .irq     (irq),
    .stc_err (stc_err)
  );

  pgb_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({wr_page, wr_addr}),
    .wdata ({in_re, in_im}),
    .raddr ({~wr_page, rd_addr}),
    .rdata (rd_data)
  );

  p_no_write_on_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ok |-> !wr_en);
endmodule

// File: tb/tb_pingpong_gate_buf.sv
module tb_pingpong_gate_buf;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int GAP = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, gate_open = 0, gate_close = 0, flip = 0, stc = 0, irq_ack = 0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [2*DW-1:0] rd_data;
  logic irq, overflow, flip_err, stc_err;

  int total = 0, bad = 0;
  bit done = 0;
  int sc = 0;
  bit gate_m = 0;
  int ptr_m = 0;
  logic [2*DW-1:0] wq[$];
  logic [2*DW-1:0] rq[$];

  always #10 clk = ~clk;

  pingpong_gate_buf #(.DATA_W(DW), .ADDR_W(AW), .FLIP_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .gate_open(gate_open), .gate_close(gate_close), .flip(flip), .stc(stc),
    .irq_ack(irq_ack), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .overflow(overflow), .flip_err(flip_err), .stc_err(stc_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes expected stored words
  task automatic drive(input bit v, input bit op, input bit cl, input bit fl,
                       input bit st, input bit ak, input int ra);
    logic [2*DW-1:0] w;
    w = {16'(sc * 3 + 1), 16'(16'hA000 + sc)};
    in_valid = v; gate_open = op; gate_close = cl; flip = fl; stc = st; irq_ack = ak;
    rd_addr = AW'(ra);
    {in_re, in_im} = w;
    if (v) sc++;
    if (v && (gate_m || op) && ptr_m < DEPTH) begin
      wq.push_back(w);
      ptr_m++;
    end
    if (fl && !(gate_m || op)) begin
      rq = wq;
      wq = {};
      ptr_m = 0;
    end
    if (cl) gate_m = 0;
    else if (op) gate_m = 1;
    @(negedge clk);
    in_valid = 0; gate_open = 0; gate_close = 0; flip = 0; stc = 0; irq_ack = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor: reads the readable page and compares against the scoreboard
  task automatic read_page(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 0, 0, i);
      check(rd_data === rq[i], tag, rd_data, rq[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(irq === 0, "R9 irq", irq, 0);
    check(overflow === 0, "R9 overflow", overflow, 0);
    check(flip_err === 0 && stc_err === 0, "R9 errs", {flip_err, stc_err}, 0);

    // R1/R2: two gate windows, samples outside discarded
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    check(wq.size() == 7, "R1 model count", wq.size(), 7);
    // R3: flip with gate closed
    drive(0, 0, 0, 1, 0, 0, 0);
    check(flip_err === 0, "R3 no flip_err", flip_err, 0);
    read_page(7, "R2/R3/R8 first page");

    // R4: flip during open gate is refused
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 1, 0, 0, 0);
    check(flip_err === 1, "R4 flip_err", flip_err, 1);
    drive(1, 0, 1, 0, 0, 0, 0);
    check(flip_err === 0, "R4 flip_err pulse", flip_err, 0);
    read_page(2, "R4 page unchanged");

    // R5: stc spacing, R3 second page
    drive(0, 0, 0, 1, 0, 0, 0);
    idle(13);
    drive(0, 0, 0, 0, 1, 0, 0);
    check(stc_err === 1, "R5 early stc_err", stc_err, 1);
    check(irq === 0, "R5 early no irq", irq, 0);
    drive(0, 0, 0, 0, 1, 0, 0);
    check(irq === 1, "R5 irq on time", irq, 1);
    check(stc_err === 0, "R5 no stc_err", stc_err, 0);
    // R6 level hold, then ack
    idle(4);
    check(irq === 1, "R6 irq held", irq, 1);
    drive(0, 0, 0, 0, 0, 1, 0);
    check(irq === 0, "R6 irq cleared", irq, 0);
    read_page(3, "R3 second page");

    // R7 overflow
    drive(1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 2; i++) drive(1, 0, 0, 0, 0, 0, 0);
    check(overflow === 1, "R7 overflow set", overflow, 1);
    drive(0, 0, 1, 0, 0, 0, 0);
    idle(2);
    check(overflow === 1, "R7 overflow sticky", overflow, 1);
    drive(0, 0, 0, 1, 0, 0, 0);
    check(overflow === 0, "R7 overflow cleared", overflow, 0);
    read_page(DEPTH, "R7 full page kept");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule